// File: doc/BRIEF.md
# Per-Core Wakeup Mask Controller

This block decides, for each of two processor cores, whether a pending interrupt may pull that core out of wait-for-interrupt. Each of up to 128 level-sensitive interrupt lines is first synchronised into the block's clock domain. It is then gated by a per-core mask bit. A core receives a registered wakeup request only while it reports that it is idling in wait-for-interrupt.

Each core owns an independent bank of 32-bit mask words. Software reads and writes these words through a word-wide register port. A set mask bit blocks the matching interrupt from waking that core, and a clear bit lets it through. Every mask bit comes out of reset set, so no source can wake either core until software opens it.

Top module: `wake_mask_ctrl`

## Requirements
- R1: After reset every mask word of both cores reads 0xFFFFFFFF, and both wakeup outputs are 0 whatever the interrupt lines do.
- R2: Mask word w (0..3) of core 0 sits at byte address 0x30 + 4*w, and mask word w of core 1 sits at 0x40 + 4*w. A write to one of these addresses is read back unchanged from the same address.
- R3: Interrupt n is governed by bit (n mod 32) of mask word (n / 32) of each core.
- R4: A mask bit of 1 keeps its interrupt from waking the core, and a mask bit of 0 lets a high interrupt wake it.
- R5: A core's wakeup output is asserted only while that core's wait-for-interrupt input is high.
- R6: The two banks are independent. A write to one core's word changes neither the other core's words nor its wakeup.
- R7: A core's wakeup output is registered and falls at the first clock edge after its wait-for-interrupt input goes low.
- R8: Interrupt lines pass through a two-flop synchroniser. A change on an interrupt line reaches the wakeup output at the third rising clock edge after it is applied.
- R9: Reads from any address outside the two banks, including addresses with bits [1:0] not zero, return 0. Writes to such addresses change no mask word.
- R10: A write takes effect at the clock edge on which the write strobe is sampled. Before that edge the old value reads back, and after it the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 128 | Level-sensitive interrupt lines, asynchronous |
| wfi_i | input | 2 | Per-core wait-for-interrupt status |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| wake_o | output | 2 | Per-core registered wakeup request |

## Verification
The bench drives one-hot interrupts at the first and last bits of a word and at a bit in a middle word, and probes the cores one at a time. A design that swapped the word index, the bit order or the mask polarity would wake the wrong core or none. It counts edges from an interrupt change to the wakeup output, and from the fall of wait-for-interrupt to the fall of wakeup. A missing synchroniser stage, or a wakeup output that is not registered, shows up as a one-cycle error. It also reads and writes just outside both banks and at misaligned offsets, where loose address decoding would alias onto a mask word.

// File: rtl/wkm_pkg.sv
package wkm_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WORD_BY = WORD_W / 8;
  localparam int unsigned BYTE_LSB = $clog2(WORD_BY);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/wkm_sync.sv
module wkm_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wkm_bank.sv
module wkm_bank
  import wkm_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE      = 'h30
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  word_t                       wdata_i,
  input  logic [NUM_WORDS*WORD_W-1:0] irq_s_i,
  input  logic                        wfi_i,
  output word_t                       rdata_o,
  output logic                        wake_o
);
  localparam int unsigned IDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned SPAN_BY = NUM_WORDS * WORD_BY;

  logic [ADDR_W-1:0]    off;
  logic                 hit;
  logic [IDX_W-1:0]     idx;
  word_t                mask_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] pend;
  logic                 wake_q;

  // window decode: in range and word aligned
  assign off = addr_i - ADDR_W'(BASE);
  assign hit = (addr_i >= ADDR_W'(BASE)) && (off < ADDR_W'(SPAN_BY)) &&
               (off[BYTE_LSB-1:0] == '0);
  assign idx = off[BYTE_LSB +: IDX_W];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[w] <= '1;
      else if (we_i && hit && (idx == IDX_W'(w))) mask_q[w] <= wdata_i;
    end
    assign pend[w] = |(irq_s_i[w*WORD_W +: WORD_W] & ~mask_q[w]);
  end

  assign rdata_o = hit ? mask_q[idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= wfi_i & (|pend);
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/wake_mask_ctrl.sv
module wake_mask_ctrl
  import wkm_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned NUM_IRQ     = 128,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_BASE   = 'h30,
  parameter int unsigned BANK_STRIDE = 'h10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   irq_i,
  input  logic [NUM_CORES-1:0] wfi_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic [NUM_CORES-1:0] wake_o
);
  localparam int unsigned NUM_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W     = NUM_WORDS * WORD_W;

  logic [NUM_IRQ-1:0] irq_s;
  logic [PAD_W-1:0]   irq_pad;
  word_t              bank_rdata [NUM_CORES];

  wkm_sync #(.W(NUM_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (irq_s)
  );

  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_IRQ-1:0] = irq_s;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    wkm_bank #(
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W),
      .BASE      (BANK_BASE + c * BANK_STRIDE)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (reg_addr_i),
      .we_i    (reg_we_i),
      .wdata_i (reg_wdata_i),
      .irq_s_i (irq_pad),
      .wfi_i   (wfi_i[c]),
      .rdata_o (bank_rdata[c]),
      .wake_o  (wake_o[c])
    );
  end

  // banks do not overlap, so an OR of their gated read data is the mux
  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CORES; c++) reg_rdata_o |= bank_rdata[c];
  end
endmodule

// File: rtl/wake_mask_ctrl_chk.sv
module wake_mask_ctrl_chk
  import wkm_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned NUM_IRQ     = 128,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_BASE   = 'h30,
  parameter int unsigned BANK_STRIDE = 'h10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_IRQ-1:0]   irq_i,
  input logic [NUM_CORES-1:0] wfi_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic                 reg_we_i,
  input logic [WORD_W-1:0]    reg_wdata_i,
  input logic [WORD_W-1:0]    reg_rdata_o,
  input logic [NUM_CORES-1:0] wake_o
);
  localparam int unsigned NUM_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(reg_addr_i) == BANK_BASE + c * BANK_STRIDE + w * WORD_BY) mapped = 1'b1;
      end
    end
  end

  a_r9_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (reg_rdata_o == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    a_r5_wake_needs_wfi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o[c] |-> $past(wfi_i[c]));
    a_r7_wake_drops_after_wfi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wfi_i[c] |=> !wake_o[c]);
    a_r8_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wake_o[c]) |-> $past(|irq_i, 3));
  end
endmodule

bind wake_mask_ctrl wake_mask_ctrl_chk #(
  .NUM_CORES   (NUM_CORES),
  .NUM_IRQ     (NUM_IRQ),
  .ADDR_W      (ADDR_W),
  .BANK_BASE   (BANK_BASE),
  .BANK_STRIDE (BANK_STRIDE)
) u_chk (.*);

// File: tb/wake_mask_ctrl_bench.sv
`timescale 1ns/1ps
module wake_mask_ctrl_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] irq_i = '0;
  logic [1:0]   wfi_i = '0;
  logic [7:0]   reg_addr_i = '0;
  logic         reg_we_i = 1'b0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic [1:0]   wake_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  wake_mask_ctrl u_wake_mask_ctrl (.*);

  typedef struct packed {
    logic [6:0] irq;
    logic [1:0] wfi;
    logic [1:0] exp;
  } vec_t;

  // masks open: core0 {5,70}, core1 {70,127}
  localparam vec_t VECS [8] = '{
    '{7'd5,   2'b11, 2'b01},
    '{7'd70,  2'b11, 2'b11},
    '{7'd127, 2'b11, 2'b10},
    '{7'd6,   2'b11, 2'b00},
    '{7'd70,  2'b01, 2'b01},
    '{7'd70,  2'b10, 2'b10},
    '{7'd127, 2'b01, 2'b00},
    '{7'd0,   2'b11, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5 d = reg_rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    for (int a = 'h30; a < 'h50; a += 4) begin
      rd(8'(a), v); chk("R1 reset mask", v, 32'hFFFF_FFFF);
    end
    chk("R1 reset wake", {30'd0, wake_o}, 32'd0);
    @(negedge clk_i); irq_i = '1; wfi_i = 2'b11;
    settle();
    chk("R1 all masked wake", {30'd0, wake_o}, 32'd0);
    irq_i = '0; wfi_i = 2'b00;

    // R9: unmapped reads and writes
    rd(8'h00, v); chk("R9 read 0x00", v, 32'd0);
    rd(8'h2C, v); chk("R9 read 0x2C", v, 32'd0);
    rd(8'h50, v); chk("R9 read 0x50", v, 32'd0);
    rd(8'h32, v); chk("R9 read misaligned 0x32", v, 32'd0);
    wr(8'h50, 32'h0); wr(8'h33, 32'h0); wr(8'h2C, 32'h0); wr(8'h41, 32'h0);
    for (int a = 'h30; a < 'h50; a += 4) begin
      rd(8'(a), v); chk("R9 unmapped write ignored", v, 32'hFFFF_FFFF);
    end

    // R10: write timing
    @(negedge clk_i);
    reg_addr_i = 8'h30; reg_wdata_i = 32'hFFFF_FFDF; reg_we_i = 1'b1;
    #0.5 chk("R10 old value before edge", reg_rdata_o, 32'hFFFF_FFFF);
    @(negedge clk_i);
    chk("R10 new value after edge", reg_rdata_o, 32'hFFFF_FFDF);
    reg_we_i = 1'b0;

    // R2/R6: layout and independence
    wr(8'h38, ~(32'd1 << 6));
    wr(8'h48, ~(32'd1 << 6));
    wr(8'h4C, ~(32'd1 << 31));
    rd(8'h40, v); chk("R6 core1 word0 untouched", v, 32'hFFFF_FFFF);
    rd(8'h4C, v); chk("R2 core1 word3", v, 32'h7FFF_FFFF);
    rd(8'h3C, v); chk("R6 core0 word3 untouched", v, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R2 core0 word2", v, 32'hFFFF_FFBF);

    // R3/R4/R5/R6: vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      irq_i = '0; irq_i[VECS[i].irq] = 1'b1; wfi_i = VECS[i].wfi;
      settle();
      chk($sformatf("R3/R4/R5/R6 vector %0d", i), {30'd0, wake_o}, {30'd0, VECS[i].exp});
      irq_i = '0; wfi_i = 2'b00;
      settle();
    end

    // R8: synchroniser latency
    @(negedge clk_i);
    wfi_i = 2'b11; irq_i = '0; irq_i[5] = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 no wake after two edges", {30'd0, wake_o}, 32'd0);
    @(negedge clk_i);
    chk("R8 wake at third edge", {30'd0, wake_o}, 32'd1);

    // R7: falls one edge after wfi drops
    wfi_i = 2'b00;
    @(negedge clk_i);
    chk("R7 wake cleared", {30'd0, wake_o}, 32'd0);
    settle();
    chk("R5 no wake without wfi", {30'd0, wake_o}, 32'd0);

    // R4: re-mask blocks
    wr(8'h30, 32'hFFFF_FFFF);
    @(negedge clk_i); wfi_i = 2'b11;
    settle();
    chk("R4 re-masked blocks", {30'd0, wake_o}, 32'd0);
    irq_i = '0; wfi_i = 2'b00;

    summary();
  end
endmodule